// File: doc/BRIEF.md
# Byte-Serial Debug Command Engine

This block sits behind a user data register of a scan-test port and turns short host frames into memory and control actions for an embedded processor. Each frame is 11 bits wide: a 3-bit channel number in the low bits and an 8-bit value above it. On the command channel, the host sends an opcode byte and then its argument bytes. The engine collects the arguments and performs one of these actions: a single-byte read or write on a simple memory master port, a 32-bit write to a processor control register, a debug-halt pulse, or a processor-reset pulse.

The host learns the outcome by capturing the same register. The captured word carries a busy flag and the last byte read from memory. The host polls until busy drops and then takes the byte. Sequential byte access does not need the full address each time: read-next and write-next step the stored address by one. The carry stops at the 16-bit boundary, because the host resends a full address whenever the low half wraps to zero.

Top module: `dbg_cmd_engine`

## Requirements
- R1: A frame carries the channel in bits [2:0] and the value in bits [10:3]. Only channel 0 is acted on. Frames on any other channel change neither the state nor the outputs, and they do not count as argument bytes.
- R2: Opcode 1 (value bits [7:4] = 1) followed by four address bytes, most significant first, raises `mem_req` with `mem_we`=0 and `mem_addr` equal to the assembled address. This happens from the clock edge that accepts the fourth byte.
- R3: Opcode 2 followed by four address bytes (most significant first) and then one data byte raises a write request (`mem_we`=1) with `mem_wdata` equal to the data byte. No request is made before the data byte arrives.
- R4: Opcode 3 (read-next) issues a read at once. Opcode 4 (write-next) waits for one data byte and then issues a write. Both use the stored address plus one, where the increment carries only within bits [15:0] and bits [31:16] stay unchanged.
- R5: Opcode 5 followed by four value bytes (most significant first) and one selector byte gives a one-cycle `csr_we` pulse. During that pulse, `csr_wdata` holds the value and `csr_sel` holds the selector.
- R6: Opcode 6 gives a one-cycle `cpu_break` pulse and opcode 7 gives a one-cycle `cpu_reset` pulse. Neither sets busy.
- R7: `cap_word` is {readback byte [10:3], busy [2], 2'b00}. Busy rises at the edge that accepts the last argument byte of a memory command. It falls at the edge where `mem_ack` is sampled high with a request pending.
- R8: At an acknowledged read, `mem_rdata` is latched into the readback byte. An acknowledged write, or an acknowledge with no request pending, leaves the readback byte unchanged.
- R9: While a request is pending, `mem_req`, `mem_addr` and `mem_we` hold steady and all incoming frames are ignored.
- R10: A zero-valued command-channel frame in the idle state does nothing. In a partly collected command, zero frames act as argument bytes, so at most five of them (plus an acknowledge, if a memory access results) return the engine to idle.
- R11: Synchronous reset returns the engine to idle and clears the stored address, the readback byte, any pending request and all pulses. A read-next right after reset therefore addresses 0x00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe marking a new host frame |
| frm_data | input | 11 | Frame: value [10:3], channel [2:0] |
| cap_word | output | 11 | Captured status: readback [10:3], busy [2], zero [1:0] |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Write data byte |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| csr_we | output | 1 | Control-register write strobe |
| csr_sel | output | 8 | Control-register number |
| csr_wdata | output | 32 | Control-register value |
| cpu_break | output | 1 | Debug-halt pulse |
| cpu_reset | output | 1 | Processor reset pulse |

## Verification
Every result of a frame is registered, so it appears at the clock edge that accepts the frame. Pulses last for exactly that one cycle. The bench drives each frame for one cycle starting at a falling edge and samples at the next falling edge, which is half a cycle after the accepting edge. It checks pulses there and checks again one cycle later for their return to zero. Busy and the readback byte change at the edge that samples the acknowledge, so they are read at the falling edge that follows that acknowledge cycle.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    localparam int DBGC_CH_W    = 3;
    localparam int DBGC_BYTE_W  = 8;
    localparam int DBGC_FRAME_W = DBGC_CH_W + DBGC_BYTE_W;
    localparam int DBGC_OP_W    = 4;

    typedef enum logic [DBGC_OP_W-1:0] {
        OP_NOP    = 4'd0,
        OP_RD_AT  = 4'd1,
        OP_WR_AT  = 4'd2,
        OP_RD_NX  = 4'd3,
        OP_WR_NX  = 4'd4,
        OP_CSR    = 4'd5,
        OP_HALT   = 4'd6,
        OP_CPURST = 4'd7
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_DATA,
        SQ_CVAL,
        SQ_CSEL
    } seq_st_e;

    typedef struct packed {
        logic                   go;
        logic                   we;
        logic [DBGC_BYTE_W-1:0] data;
    } mem_issue_t;

    function automatic op_e op_of(input logic [DBGC_BYTE_W-1:0] v);
        return op_e'(v[DBGC_BYTE_W-1 -: DBGC_OP_W]);
    endfunction

endpackage

// File: rtl/dbgc_frame_rx.sv
module dbgc_frame_rx
    import dbgc_pkg::*;
#(
    parameter int CHAN = 0
) (
    input  logic                     frm_valid,
    input  logic [DBGC_FRAME_W-1:0]  frm_data,
    input  logic                     busy,
    output logic                     acc_o,
    output logic [DBGC_BYTE_W-1:0]   val_o
);
    localparam logic [DBGC_CH_W-1:0] OWN_CH = DBGC_CH_W'(CHAN);

    logic [DBGC_CH_W-1:0] ch;

    always_comb begin
        ch    = frm_data[DBGC_CH_W-1:0];
        val_o = frm_data[DBGC_FRAME_W-1:DBGC_CH_W];
        acc_o = frm_valid && (ch == OWN_CH) && !busy;
    end
endmodule

// File: rtl/dbgc_seq.sv
module dbgc_seq
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INC_W  = 16,
    parameter int CSR_W  = 32,
    parameter int SEL_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_i,
    input  logic [DBGC_BYTE_W-1:0]  val_i,
    output logic [ADDR_W-1:0]       addr_o,
    output mem_issue_t              iss_o,
    output logic                    csr_we_o,
    output logic [SEL_W-1:0]        csr_sel_o,
    output logic [CSR_W-1:0]        csr_wdata_o,
    output logic                    halt_o,
    output logic                    cpurst_o
);
    localparam int ADDR_N = ADDR_W / DBGC_BYTE_W;
    localparam int CVAL_N = CSR_W / DBGC_BYTE_W;
    localparam int CNT_W  = $clog2(ADDR_N + CVAL_N);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_N - 1);
    localparam logic [CNT_W-1:0] CVAL_LAST = CNT_W'(CVAL_N - 1);

    seq_st_e           st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              op_wr_q;
    logic              nxt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CSR_W-1:0]  cval_q;
    logic              bump;
    op_e               op;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:INC_W], a[INC_W-1:0] + 1'b1};
    endfunction

    always_comb begin
        op         = op_of(val_i);
        iss_o.go   = 1'b0;
        iss_o.we   = 1'b0;
        iss_o.data = val_i;
        bump       = 1'b0;
        if (acc_i) begin
            unique case (st_q)
                SQ_IDLE: if (op == OP_RD_NX) begin
                    iss_o.go = 1'b1;
                    bump     = 1'b1;
                end
                SQ_ADDR: if (cnt_q == ADDR_LAST && !op_wr_q) iss_o.go = 1'b1;
                SQ_DATA: begin
                    iss_o.go = 1'b1;
                    iss_o.we = 1'b1;
                    bump     = nxt_q;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SQ_IDLE;
            cnt_q     <= '0;
            op_wr_q   <= 1'b0;
            nxt_q     <= 1'b0;
            addr_q    <= '0;
            cval_q    <= '0;
            csr_we_o  <= 1'b0;
            csr_sel_o <= '0;
            halt_o    <= 1'b0;
            cpurst_o  <= 1'b0;
        end else begin
            csr_we_o <= 1'b0;
            halt_o   <= 1'b0;
            cpurst_o <= 1'b0;
            if (bump) addr_q <= step_addr(addr_q);
            if (acc_i) begin
                unique case (st_q)
                    SQ_IDLE: begin
                        cnt_q <= '0;
                        nxt_q <= (op == OP_WR_NX);
                        case (op)
                            OP_RD_AT:  begin st_q <= SQ_ADDR; op_wr_q <= 1'b0; end
                            OP_WR_AT:  begin st_q <= SQ_ADDR; op_wr_q <= 1'b1; end
                            OP_WR_NX:  st_q <= SQ_DATA;
                            OP_CSR:    st_q <= SQ_CVAL;
                            OP_HALT:   halt_o   <= 1'b1;
                            OP_CPURST: cpurst_o <= 1'b1;
                            default:   ;
                        endcase
                    end
                    SQ_ADDR: begin
                        addr_q <= {addr_q[ADDR_W-DBGC_BYTE_W-1:0], val_i};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == ADDR_LAST) st_q <= op_wr_q ? SQ_DATA : SQ_IDLE;
                    end
                    SQ_DATA: st_q <= SQ_IDLE;
                    SQ_CVAL: begin
                        cval_q <= {cval_q[CSR_W-DBGC_BYTE_W-1:0], val_i};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CVAL_LAST) st_q <= SQ_CSEL;
                    end
                    SQ_CSEL: begin
                        csr_we_o  <= 1'b1;
                        csr_sel_o <= val_i[SEL_W-1:0];
                        st_q      <= SQ_IDLE;
                    end
                    default: st_q <= SQ_IDLE;
                endcase
            end
        end
    end

    assign addr_o      = addr_q;
    assign csr_wdata_o = cval_q;

    AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> !halt_o) else $error("halt pulse too long"); // R6
    AST_CPURST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpurst_o |=> !cpurst_o) else $error("reset pulse too long"); // R6
    AST_CSR_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
        csr_we_o |=> !csr_we_o) else $error("csr strobe too long"); // R5
    AST_CTRL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({csr_we_o, halt_o, cpurst_o})) else $error("control pulses overlap"); // R6
    AST_STEP_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        bump |=> addr_q[ADDR_W-1:INC_W] == $past(addr_q[ADDR_W-1:INC_W]))
        else $error("increment crossed the low boundary"); // R4
endmodule

// File: rtl/dbgc_mem_port.sv
module dbgc_mem_port
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  mem_issue_t              iss_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    ack_i,
    input  logic [DBGC_BYTE_W-1:0]  rdata_i,
    output logic                    req_o,
    output logic                    we_o,
    output logic [DBGC_BYTE_W-1:0]  wdata_o,
    output logic [DBGC_BYTE_W-1:0]  rdbk_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_o   <= 1'b0;
            we_o    <= 1'b0;
            wdata_o <= '0;
            rdbk_o  <= '0;
        end else if (req_o) begin
            if (ack_i) begin
                req_o <= 1'b0;
                if (!we_o) rdbk_o <= rdata_i;
            end
        end else if (iss_i.go) begin
            req_o   <= 1'b1;
            we_o    <= iss_i.we;
            wdata_o <= iss_i.data;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_o && !ack_i |=> req_o && $stable(addr_i) && $stable(we_o))
        else $error("request dropped or changed before ack"); // R9
    AST_ACK_ENDS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_o && ack_i |=> !req_o) else $error("request outlived ack"); // R7
    AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_o |-> !iss_i.go) else $error("issue while busy"); // R9
    AST_RDBK_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !(req_o && ack_i && !we_o) |=> $stable(rdbk_o))
        else $error("readback changed without a read ack"); // R8
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int INC_W  = 16,
    parameter int CSR_W  = 32,
    parameter int SEL_W  = 8,
    parameter int CHAN   = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frm_valid,
    input  logic [DBGC_FRAME_W-1:0] frm_data,
    output logic [DBGC_FRAME_W-1:0] cap_word,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DBGC_BYTE_W-1:0]  mem_wdata,
    input  logic                    mem_ack,
    input  logic [DBGC_BYTE_W-1:0]  mem_rdata,
    output logic                    csr_we,
    output logic [SEL_W-1:0]        csr_sel,
    output logic [CSR_W-1:0]        csr_wdata,
    output logic                    cpu_break,
    output logic                    cpu_reset
);
    logic                   acc;
    logic [DBGC_BYTE_W-1:0] val;
    logic [DBGC_BYTE_W-1:0] rdbk;
    mem_issue_t             iss;

    dbgc_frame_rx #(.CHAN(CHAN)) u_rx (
        .frm_valid (frm_valid),
        .frm_data  (frm_data),
        .busy      (mem_req),
        .acc_o     (acc),
        .val_o     (val)
    );

    dbgc_seq #(.ADDR_W(ADDR_W), .INC_W(INC_W), .CSR_W(CSR_W), .SEL_W(SEL_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .acc_i       (acc),
        .val_i       (val),
        .addr_o      (mem_addr),
        .iss_o       (iss),
        .csr_we_o    (csr_we),
        .csr_sel_o   (csr_sel),
        .csr_wdata_o (csr_wdata),
        .halt_o      (cpu_break),
        .cpurst_o    (cpu_reset)
    );

    dbgc_mem_port #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .iss_i   (iss),
        .addr_i  (mem_addr),
        .ack_i   (mem_ack),
        .rdata_i (mem_rdata),
        .req_o   (mem_req),
        .we_o    (mem_we),
        .wdata_o (mem_wdata),
        .rdbk_o  (rdbk)
    );

    assign cap_word = {rdbk, mem_req, 2'b00};
endmodule

// File: tb/dbg_cmd_engine_test.sv
module dbg_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [10:0] frm_data = '0;
    logic [10:0] cap_word;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        csr_we;
    logic [7:0]  csr_sel;
    logic [31:0] csr_wdata;
    logic        cpu_break, cpu_reset;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbg_cmd_engine uut (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
        .cap_word(cap_word), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .cpu_break(cpu_break), .cpu_reset(cpu_reset)
    );

    // read-at-address vectors: {address, byte returned by memory}
    localparam logic [39:0] RD_VEC [4] = '{
        {32'h0000_0010, 8'hA5},
        {32'hFFFF_FFFE, 8'h00},
        {32'h8001_2345, 8'h5C},
        {32'h1234_FFFF, 8'h96}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic [2:0] ch, input logic [7:0] v);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_data  = {v, ch};
        @(negedge clk);
        frm_valid = 1'b0;
        frm_data  = '0;
    endtask

    task automatic give_ack(input logic [7:0] d);
        @(negedge clk);
        mem_ack   = 1'b1;
        mem_rdata = d;
        @(negedge clk);
        mem_ack   = 1'b0;
        mem_rdata = '0;
    endtask

    task automatic send_addr(input logic [3:0] op, input logic [31:0] a);
        frame(3'd0, {op, 4'h0});
        for (int i = 0; i < 4; i++) frame(3'd0, a[31 - 8*i -: 8]);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 cap_word after reset", cap_word, 0);
        chk("R11 no request after reset", mem_req, 0);
        chk("R11 no pulses after reset", {cpu_break, cpu_reset, csr_we}, 0);
        frame(3'd0, 8'h30);
        chk("R11 read-next from cleared address", mem_addr, 32'h0000_0001);
        chk("R4 read-next issues read", {mem_req, mem_we}, 2'b10);
        give_ack(8'h3C);
        chk("R8 read data latched", cap_word[10:3], 8'h3C);

        // R2 R7 R8 table walk
        for (int i = 0; i < 4; i++) begin
            send_addr(4'd1, RD_VEC[i][39:8]);
            chk("R2 read request", {mem_req, mem_we}, 2'b10);
            chk("R2 read address", mem_addr, RD_VEC[i][39:8]);
            chk("R7 busy raised", cap_word[2], 1'b1);
            give_ack(RD_VEC[i][7:0]);
            chk("R7 busy cleared", cap_word[2], 1'b0);
            chk("R8 readback byte", cap_word[10:3], RD_VEC[i][7:0]);
            chk("R7 low bits zero", cap_word[1:0], 2'b00);
        end

        // R4 increment stays inside the low 16 bits
        frame(3'd0, 8'h30);
        chk("R4 read-next wraps low half", mem_addr, 32'h1234_0000);
        give_ack(8'h11);
        frame(3'd0, 8'h40);
        chk("R4 write-next waits for data", mem_req, 1'b0);
        frame(3'd0, 8'h5A);
        chk("R4 write-next request", {mem_req, mem_we}, 2'b11);
        chk("R4 write-next address", mem_addr, 32'h1234_0001);
        chk("R4 write-next data", mem_wdata, 8'h5A);
        give_ack(8'hEE);
        chk("R8 write ack keeps readback", cap_word[10:3], 8'h11);

        // R3 write-at-address, R9 frames ignored while busy
        send_addr(4'd2, 32'h8000_0004);
        chk("R3 no request before data", mem_req, 1'b0);
        frame(3'd0, 8'hC3);
        chk("R3 write request", {mem_req, mem_we}, 2'b11);
        chk("R3 write address", mem_addr, 32'h8000_0004);
        chk("R3 write data", mem_wdata, 8'hC3);
        frame(3'd0, 8'h70);
        chk("R9 command ignored while busy", cpu_reset, 1'b0);
        frame(3'd0, 8'h12);
        chk("R9 address held while busy", mem_addr, 32'h8000_0004);
        chk("R9 request held while busy", {mem_req, mem_we, mem_wdata}, {2'b11, 8'hC3});
        give_ack(8'h00);
        give_ack(8'h77);
        chk("R8 stray ack ignored", cap_word[10:3], 8'h11);

        // R1 other channels ignored
        frame(3'd1, 8'h70);
        chk("R1 channel 1 command ignored", cpu_reset, 1'b0);
        frame(3'd0, 8'h10);
        frame(3'd0, 8'hDE);
        frame(3'd2, 8'h55);
        frame(3'd5, 8'hFF);
        frame(3'd0, 8'hAD);
        frame(3'd0, 8'hBE);
        chk("R1 foreign bytes not counted", mem_req, 1'b0);
        frame(3'd0, 8'hEF);
        chk("R1 address without foreign bytes", mem_addr, 32'hDEAD_BEEF);
        give_ack(8'h42);

        // R5 control register write
        frame(3'd0, 8'h50);
        frame(3'd0, 8'hCA); frame(3'd0, 8'hFE); frame(3'd0, 8'hF0); frame(3'd0, 8'h0D);
        chk("R5 no strobe before selector", csr_we, 1'b0);
        frame(3'd0, 8'h03);
        chk("R5 strobe", csr_we, 1'b1);
        chk("R5 value", csr_wdata, 32'hCAFE_F00D);
        chk("R5 selector", csr_sel, 8'h03);
        @(negedge clk);
        chk("R5 strobe one cycle", csr_we, 1'b0);

        // R6 pulses
        frame(3'd0, 8'h60);
        chk("R6 halt pulse", cpu_break, 1'b1);
        chk("R6 halt leaves busy low", cap_word[2], 1'b0);
        @(negedge clk);
        chk("R6 halt one cycle", cpu_break, 1'b0);
        frame(3'd0, 8'h70);
        chk("R6 reset pulse", cpu_reset, 1'b1);
        chk("R6 reset leaves busy low", cap_word[2], 1'b0);
        @(negedge clk);
        chk("R6 reset one cycle", cpu_reset, 1'b0);

        // R10 idle no-op and recovery
        frame(3'd0, 8'h00);
        chk("R10 idle no-op silent", {mem_req, csr_we, cpu_break, cpu_reset}, 4'b0);
        frame(3'd0, 8'h20); frame(3'd0, 8'hAB); frame(3'd0, 8'hCD);
        frame(3'd0, 8'h00); frame(3'd0, 8'h00); frame(3'd0, 8'h00);
        chk("R10 zeros complete write", {mem_req, mem_we, mem_wdata}, {2'b11, 8'h00});
        chk("R10 zeros complete address", mem_addr, 32'hABCD_0000);
        give_ack(8'h00);
        frame(3'd0, 8'h00); frame(3'd0, 8'h00);
        frame(3'd0, 8'h60);
        chk("R10 idle again after write", cpu_break, 1'b1);
        frame(3'd0, 8'h50); frame(3'd0, 8'h99);
        for (int i = 0; i < 4; i++) frame(3'd0, 8'h00);
        chk("R10 zeros complete csr write", {csr_we, csr_wdata, csr_sel}, {1'b1, 32'h9900_0000, 8'h00});
        frame(3'd0, 8'h60);
        chk("R10 idle again after csr", cpu_break, 1'b1);

        // R11 reset mid-command
        frame(3'd0, 8'h10); frame(3'd0, 8'h44); frame(3'd0, 8'h55);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R11 cap_word cleared", cap_word, 0);
        frame(3'd0, 8'h30);
        chk("R11 idle and address cleared", mem_addr, 32'h0000_0001);
        give_ack(8'h01);

        finish_run();
    end
endmodule